// File: doc/BRIEF.md
# Line-Locked Clock Divider and Reset Sequencer

This block sits behind an analog frequency multiplier. It turns that multiplier's fast, line-locked master timebase into the clocks a digital video chain needs. The block runs on a sampling clock at twice the master-clock rate, and a two-bit phase counter walks through four phases. From this it makes two identical copies of a master-rate clock, two identical copies of a half-rate clock, and one qualifier clock. The qualifier runs at the half rate, shifted by one sampling cycle, so that its high phase is centred on each rising edge of the half-rate clock.

The block also owns the system reset output, which is active low. Three kinds of event start a reset sequence: power-on, a brown-out flag, or chip-enable being applied. The sequence also restarts whenever the selected line-reference indication is missing. The reset output stays low until a programmable number of quiet cycles has elapsed. While reset is low, every clock output is parked high. When the block releases, the phase counter starts from a phase in which all clocks are high, so the first high phase after release is never shortened.

Top module: `llc_clkgen`

## Requirements
- R1: While `rst_ni` is low, all five clock outputs are high and `sys_rst_no` is low. After `rst_ni` rises with `ce_i` high, the first sampling edge counts as a chip-enable restart.
- R2: At the first rising edge of `clk_i` at which `ce_i` is sampled low, and at every later edge while it stays low, all clock outputs go high and `sys_rst_no` goes low.
- R3: Let k be the last rising edge at which a restart condition is sampled. The restart conditions are: `brownout_i` high, `ce_i` low, `ce_i` high after having been sampled low, or the selected reference indication low. Then `sys_rst_no` rises at edge k+`wait_len_i`+1, and it stays high until the next restart.
- R4: A restart that arrives while a delay is already counting starts the count again from zero.
- R5: Number the cycles after the release edge from j = 0. The master-rate outputs are high when j is even and low when j is odd. This gives a period of two sampling cycles, a 50% duty cycle, and a full first high phase.
- R6: The half-rate outputs are high when j mod 4 is 0 or 1, and low when j mod 4 is 2 or 3.
- R7: `fast_a_o` always equals `fast_b_o`, and `half_a_o` always equals `half_b_o`.
- R8: The qualifier output is high when j mod 4 is 0 or 3, and low when j mod 4 is 1 or 2.
- R9: With `src_sel_i` low, only `ref1_ok_i` is used as the reference indication. With `src_sel_i` high, only `ref2_ok_i` is used. The unselected indication has no effect on `sys_rst_no`.
- R10: If `wait_len_i` is lowered to a value at or below the number of cycles already counted, `sys_rst_no` rises at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock, twice the master-clock rate |
| rst_ni | input | 1 | Asynchronous power-on reset, active low |
| ce_i | input | 1 | Chip enable; low parks the clocks and asserts reset |
| brownout_i | input | 1 | Supply-drop flag; high restarts the reset sequence |
| src_sel_i | input | 1 | Reference select: 0 uses ref1_ok_i, 1 uses ref2_ok_i |
| ref1_ok_i | input | 1 | Reference indication, source 1 |
| ref2_ok_i | input | 1 | Reference indication, source 2 |
| wait_len_i | input | DLY_W | Reset stretch length in sampling cycles |
| fast_a_o | output | 1 | Master-rate clock, copy A |
| fast_b_o | output | 1 | Master-rate clock, copy B |
| half_a_o | output | 1 | Half-rate clock, copy A |
| half_b_o | output | 1 | Half-rate clock, copy B |
| qual_o | output | 1 | Qualifier clock centred on half-rate rising edges |
| sys_rst_no | output | 1 | Stretched system reset, active low |

## Verification
The bench sweeps the stretch length from zero upward and counts the edges from the last restart to release. A design whose counter is off by one releases one edge early or late. A design with a wrapping counter never releases at all. After every release the bench compares the full four-phase pattern of all outputs. A divider that keeps its phase across reset gating instead of restarting from the all-high phase shows up as a runt or inverted first pulse. The remaining checks target the following behaviours:
- A second restart during a count: a counter that fails to clear releases early.
- A stretch length lowered below the elapsed count: an equality compare would run to wrap-around.
- Toggling the unselected reference: a swapped or merged select visibly drops the reset.

// File: rtl/llc_pkg.sv
package llc_pkg;

  localparam int PHASE_W = 2;
  localparam int NUM_COPIES = 2;

  typedef logic [PHASE_W-1:0] phase_t;

  typedef struct packed {
    logic fast;
    logic half;
    logic qual;
  } clk_lvls_t;

  // Master-rate level: high on even phases.
  function automatic logic fast_level(phase_t p);
    return ~p[0];
  endfunction

  // Half-rate level: high on phases 0 and 1.
  function automatic logic half_level(phase_t p);
    return ~p[1];
  endfunction

  // Qualifier: high on phases 3 and 0, centred on the half-rate rise.
  function automatic logic qual_level(phase_t p);
    return ~(p[1] ^ p[0]);
  endfunction

  // All levels for one phase; parked high when not running.
  function automatic clk_lvls_t levels(logic run, phase_t p);
    clk_lvls_t l;
    if (!run) begin
      l = '{fast: 1'b1, half: 1'b1, qual: 1'b1};
    end else begin
      l.fast = fast_level(p);
      l.half = half_level(p);
      l.qual = qual_level(p);
    end
    return l;
  endfunction

  // Next phase: held at the all-high phase while gated.
  function automatic phase_t next_phase(logic run, phase_t p);
    return run ? phase_t'(p + 1'b1) : '0;
  endfunction

endpackage

// File: rtl/llc_trig.sv
module llc_trig (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ce_i,
  input  logic brownout_i,
  input  logic src_sel_i,
  input  logic ref1_ok_i,
  input  logic ref2_ok_i,
  output logic restart_o
);

  logic ce_q;
  logic ref_ok;
  logic ce_rise;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ce_q <= 1'b0;
    else         ce_q <= ce_i;
  end

  assign ref_ok    = src_sel_i ? ref2_ok_i : ref1_ok_i;
  assign ce_rise   = ce_i & ~ce_q;
  assign restart_o = ~ce_i | ce_rise | brownout_i | ~ref_ok;

  AST_CE_LOW_RESTARTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ce_i |-> restart_o); // R2

endmodule

// File: rtl/llc_rst_seq.sv
module llc_rst_seq #(
  parameter int DLY_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  input  logic [DLY_W-1:0] wait_len_i,
  output logic             run_q_o,
  output logic             run_d_o
);

  logic [DLY_W-1:0] cnt_q, cnt_d;
  logic             run_q, run_d;
  logic             wait_met;

  function automatic logic delay_met(logic [DLY_W-1:0] cnt, logic [DLY_W-1:0] len);
    return cnt >= len;
  endfunction

  assign wait_met = delay_met(cnt_q, wait_len_i);

  always_comb begin
    if (restart_i) begin
      run_d = 1'b0;
      cnt_d = '0;
    end else if (run_q || wait_met) begin
      run_d = 1'b1;
      cnt_d = cnt_q;
    end else begin
      run_d = 1'b0;
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      run_q <= run_d;
      cnt_q <= cnt_d;
    end
  end

  assign run_q_o = run_q;
  assign run_d_o = run_d;

  AST_RESTART_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> (!run_q && cnt_q == '0)); // R4

  AST_RELEASE_AFTER_WAIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(run_q) |-> $past(cnt_q) >= $past(wait_len_i)); // R3

  AST_RUN_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && !restart_i) |=> run_q); // R3

endmodule

// File: rtl/llc_phase_gen.sv
module llc_phase_gen
  import llc_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  run_q_i,
  input  logic                  run_d_i,
  output logic [NUM_COPIES-1:0] fast_o,
  output logic [NUM_COPIES-1:0] half_o,
  output logic                  qual_o
);

  phase_t    phase_q, phase_d;
  clk_lvls_t lvl_d;

  assign phase_d = next_phase(run_q_i, phase_q);
  assign lvl_d   = levels(run_d_i, phase_d);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= '0;
      qual_o  <= 1'b1;
    end else begin
      phase_q <= phase_d;
      qual_o  <= lvl_d.qual;
    end
  end

  for (genvar c = 0; c < NUM_COPIES; c++) begin : g_copy
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        fast_o[c] <= 1'b1;
        half_o[c] <= 1'b1;
      end else begin
        fast_o[c] <= lvl_d.fast;
        half_o[c] <= lvl_d.half;
      end
    end

    AST_COPY_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (fast_o[c] == fast_o[0]) && (half_o[c] == half_o[0])); // R7
  end

  AST_GATED_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_q_i |-> (fast_o[0] && half_o[0] && qual_o)); // R2

  AST_FAST_TOGGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q_i && $past(run_q_i)) |-> (fast_o[0] != $past(fast_o[0]))); // R5

  AST_HALF_ON_FAST_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q_i && $past(run_q_i) && half_o[0] != $past(half_o[0])) |-> fast_o[0]); // R6

  AST_QUAL_ON_FAST_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q_i && $past(run_q_i) && qual_o != $past(qual_o)) |-> !fast_o[0]); // R8

endmodule

// File: rtl/llc_clkgen.sv
module llc_clkgen
  import llc_pkg::*;
#(
  parameter int DLY_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ce_i,
  input  logic             brownout_i,
  input  logic             src_sel_i,
  input  logic             ref1_ok_i,
  input  logic             ref2_ok_i,
  input  logic [DLY_W-1:0] wait_len_i,
  output logic             fast_a_o,
  output logic             fast_b_o,
  output logic             half_a_o,
  output logic             half_b_o,
  output logic             qual_o,
  output logic             sys_rst_no
);

  logic                  restart;
  logic                  run_q, run_d;
  logic [NUM_COPIES-1:0] fast, half;

  llc_trig i_trig (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ce_i       (ce_i),
    .brownout_i (brownout_i),
    .src_sel_i  (src_sel_i),
    .ref1_ok_i  (ref1_ok_i),
    .ref2_ok_i  (ref2_ok_i),
    .restart_o  (restart)
  );

  llc_rst_seq #(.DLY_W(DLY_W)) i_rst_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .restart_i  (restart),
    .wait_len_i (wait_len_i),
    .run_q_o    (run_q),
    .run_d_o    (run_d)
  );

  llc_phase_gen i_phase_gen (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_q_i (run_q),
    .run_d_i (run_d),
    .fast_o  (fast),
    .half_o  (half),
    .qual_o  (qual_o)
  );

  assign fast_a_o   = fast[0];
  assign fast_b_o   = fast[1];
  assign half_a_o   = half[0];
  assign half_b_o   = half[1];
  assign sys_rst_no = run_q;

  AST_CE_LOW_HOLDS_RESET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ce_i |=> (!sys_rst_no && fast_a_o && half_b_o)); // R2

endmodule

// File: tb/test_llc_clkgen.sv
module test_llc_clkgen;

  logic       clk = 1'b0;
  logic       rst_ni, ce, brownout, sel, ref1, ref2;
  logic [7:0] wait_len;
  logic       fast_a, fast_b, half_a, half_b, qual, sys_rst_n;

  int  n_checks = 0;
  int  n_fails  = 0;
  bit  finished = 1'b0;

  always #4 clk = ~clk;

  llc_clkgen #(.DLY_W(8)) i_llc_clkgen (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .ce_i       (ce),
    .brownout_i (brownout),
    .src_sel_i  (sel),
    .ref1_ok_i  (ref1),
    .ref2_ok_i  (ref2),
    .wait_len_i (wait_len),
    .fast_a_o   (fast_a),
    .fast_b_o   (fast_b),
    .half_a_o   (half_a),
    .half_b_o   (half_b),
    .qual_o     (qual),
    .sys_rst_no (sys_rst_n)
  );

  task automatic check(string req, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_parked(string req);
    check({req, " sys_rst_no"}, sys_rst_n, 0);
    check({req, " clocks high"}, {fast_a, fast_b, half_a, half_b, qual}, 5'b11111);
  endtask

  // Counts edges until sys_rst_no rises; clocks must stay parked meanwhile.
  task automatic measure(string req, int exp);
    int n = 0;
    int bad = 0;
    do begin
      @(posedge clk);
      @(negedge clk);
      n++;
      if (!sys_rst_n && {fast_a, fast_b, half_a, half_b, qual} != 5'b11111) bad++;
    end while (!sys_rst_n && n < 400);
    check({req, " release edge"}, n, exp);
    check("R2 clocks parked during stretch", bad, 0);
  endtask

  // Called at the negedge right after the release edge (j = 0).
  task automatic check_wave(int cycles);
    for (int j = 0; j < cycles; j++) begin
      int m = j % 4;
      check("R5 fast A", fast_a, (j % 2 == 0));
      check("R7 fast B", fast_b, (j % 2 == 0));
      check("R6 half A", half_a, (m < 2));
      check("R7 half B", half_b, (m < 2));
      check("R8 qual", qual, (m == 0 || m == 3));
      @(negedge clk);
    end
  endtask

  task automatic pulse_brownout();
    brownout = 1'b1;
    @(negedge clk);
    brownout = 1'b0;
  endtask

  initial begin
    rst_ni = 1'b0; ce = 1'b1; brownout = 1'b0;
    sel = 1'b0; ref1 = 1'b1; ref2 = 1'b1; wait_len = 8'd5;

    // R1 reset state
    repeat (3) begin
      @(negedge clk);
      check_parked("R1 in reset");
    end
    rst_ni = 1'b1;
    measure("R1 power-on", 5 + 2);
    check_wave(8);

    // R3 sweep of stretch length, with R5 R6 R7 R8 pattern after each release
    for (int len = 0; len <= 12; len++) begin
      wait_len = 8'(len);
      pulse_brownout();
      measure("R3 sweep", len + 1);
      check_wave(12);
    end

    // R4 restart during a running count
    wait_len = 8'd10;
    pulse_brownout();
    repeat (6) @(negedge clk);
    check("R4 still low mid-count", sys_rst_n, 0);
    pulse_brownout();
    measure("R4 restart from zero", 11);
    check_wave(4);

    // R10 stretch length lowered below the elapsed count
    wait_len = 8'd20;
    pulse_brownout();
    repeat (8) @(negedge clk);
    check("R10 low before change", sys_rst_n, 0);
    wait_len = 8'd3;
    @(negedge clk);
    check("R10 release on next edge", sys_rst_n, 1);
    check_wave(8);

    // R2 chip enable low
    ce = 1'b0;
    @(negedge clk);
    check_parked("R2 first edge ce low");
    repeat (4) begin
      @(negedge clk);
      check_parked("R2 ce held low");
    end
    ce = 1'b1;
    measure("R2 ce reapplied", 3 + 2);
    check_wave(4);

    // R9 source select
    ref2 = 1'b0;
    repeat (6) begin
      @(negedge clk);
      check("R9 unselected ref2 ignored", sys_rst_n, 1);
    end
    ref1 = 1'b0;
    @(negedge clk);
    check("R9 selected ref1 lost", sys_rst_n, 0);
    sel = 1'b1; ref2 = 1'b1;
    measure("R9 switch to ref2", 3 + 1);
    check_wave(4);
    ref1 = 1'b1;
    @(negedge clk);
    ref1 = 1'b0;
    repeat (5) begin
      @(negedge clk);
      check("R9 unselected ref1 ignored", sys_rst_n, 1);
    end
    ref2 = 1'b0;
    @(negedge clk);
    check("R9 selected ref2 lost", sys_rst_n, 0);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

endmodule